// File: doc/BRIEF.md
# Processor Status and Mode Register

This block holds the eight condition and mode flags of an 8/16-bit CPU together with a hidden emulation bit. Each accepted command updates the flags in one step. A command can set or clear one flag, set or clear a group of flags selected by a mask, exchange carry with the emulation bit, load all eight flags from a data bus after a stack pull, or merge ALU results into the flags under a write mask. The block drives the accumulator and index width selects straight from the stored flags.

Commands arrive as a valid/ready stream, one command per beat. `cmd_ready` is held high at all times, so the block never applies back-pressure. A beat is taken on every rising clock edge that sees `cmd_valid` high. Its effect shows on the outputs after that edge. While the emulation bit is set, both width bits are held at 1 (8-bit operation). Whenever the index width bit changes from 0 to 1, the block raises a one-cycle strobe so that the register file can zero the high bytes of X and Y.

Top module: `cpu_status_reg`

## Requirements
- R1: An active-low reset sets the flags to 0x34 and the emulation bit to 1, with the strobe low. That value means interrupt-disable (bit 2), index width (bit 4) and accumulator width (bit 5) are 1, and decimal (bit 3) and all other flags are 0.
- R2: The flag bit positions are: 0 carry, 1 zero, 2 interrupt-disable, 3 decimal, 4 index width, 5 accumulator width, 6 overflow, 7 negative. Opcodes 1..7 act on a single flag: 1 clears carry, 2 clears decimal, 3 clears interrupt-disable, 4 clears overflow, 5 sets carry, 6 sets decimal, 7 sets interrupt-disable.
- R3: Opcode 8 clears each flag whose bit in `cmd_data` is 1 and leaves the flags whose bit is 0 unchanged.
- R4: Opcode 9 sets each flag whose bit in `cmd_data` is 1 and leaves the flags whose bit is 0 unchanged.
- R5: Opcode 10 writes the old carry into the emulation bit and the old emulation bit into carry. When this enters native mode, the accumulator width bit reads 1.
- R6: Opcode 11 replaces all eight flags with `cmd_data`.
- R7: Opcode 12 writes `cmd_data` into the flags whose bit in `cmd_mask` is 1 and leaves the other flags unchanged.
- R8: While the emulation bit is 1, bits 4 and 5 read 1 after every command, including a mask clear that targets them. `idx_8bit` always equals bit 4 and `acc_8bit` always equals bit 5.
- R9: `idx_hi_clr` is high for exactly the one cycle in which bit 4 first reads 1 after reading 0. It is low at all other times.
- R10: A cycle with `cmd_valid` low, or a beat with opcode 0, 13, 14 or 15, changes no output. `cmd_ready` is always 1.
- R11: An accepted command shows on the outputs right after the clock edge that takes it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Always 1; command accepted |
| cmd_op | input | 4 | Command opcode |
| cmd_data | input | 8 | Mask (opcodes 8, 9), pulled value (11), ALU flag values (12) |
| cmd_mask | input | 8 | ALU write mask (opcode 12) |
| flags | output | 8 | Stored flag bits |
| emu | output | 1 | Emulation bit |
| acc_8bit | output | 1 | Accumulator width select, 1 = 8-bit |
| idx_8bit | output | 1 | Index width select, 1 = 8-bit |
| idx_hi_clr | output | 1 | One-cycle strobe on index width rising to 1 |

## Verification
A wrong internal state shows on the flag and emulation outputs in the cycle after the command that caused it. The error then persists, because the register only changes again through later commands. A missed width transition shows in the same cycle as a missing or extra strobe. Every output is therefore compared against a reference model after every beat. Directed cases cover the emulation lock on the width bits, the exchange in both directions and the strobe edge, and random beats fill in the rest.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int FLAG_W  = 8;
  localparam int OP_W    = 4;
  localparam int B_CARRY = 0;
  localparam int B_ZERO  = 1;
  localparam int B_IRQD  = 2;
  localparam int B_DEC   = 3;
  localparam int B_XW    = 4;
  localparam int B_MW    = 5;
  localparam int B_OVF   = 6;
  localparam int B_NEG   = 7;
  localparam logic [FLAG_W-1:0] RESET_FLAGS = 8'h34;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE   = 4'd0,
    OP_CLR_C  = 4'd1,
    OP_CLR_D  = 4'd2,
    OP_CLR_I  = 4'd3,
    OP_CLR_V  = 4'd4,
    OP_SET_C  = 4'd5,
    OP_SET_D  = 4'd6,
    OP_SET_I  = 4'd7,
    OP_MCLR   = 4'd8,
    OP_MSET   = 4'd9,
    OP_SWAPCE = 4'd10,
    OP_PULL   = 4'd11,
    OP_ALUWR  = 4'd12
  } psr_op_e;
endpackage

// File: rtl/psr_next_logic.sv
module psr_next_logic
  import psr_pkg::*;
(
  input  logic              take,
  input  logic [OP_W-1:0]   op,
  input  logic [FLAG_W-1:0] data,
  input  logic [FLAG_W-1:0] wmask,
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic              cur_emu,
  output logic [FLAG_W-1:0] nxt_flags,
  output logic              nxt_emu
);
  logic [FLAG_W-1:0] raw;
  logic              raw_emu;

  always_comb begin
    raw     = cur_flags;
    raw_emu = cur_emu;
    if (take) begin
      case (op)
        OP_CLR_C:  raw[B_CARRY] = 1'b0;
        OP_CLR_D:  raw[B_DEC]   = 1'b0;
        OP_CLR_I:  raw[B_IRQD]  = 1'b0;
        OP_CLR_V:  raw[B_OVF]   = 1'b0;
        OP_SET_C:  raw[B_CARRY] = 1'b1;
        OP_SET_D:  raw[B_DEC]   = 1'b1;
        OP_SET_I:  raw[B_IRQD]  = 1'b1;
        OP_MCLR:   raw = cur_flags & ~data;
        OP_MSET:   raw = cur_flags | data;
        OP_SWAPCE: begin
          raw[B_CARRY] = cur_emu;
          raw_emu      = cur_flags[B_CARRY];
        end
        OP_PULL:   raw = data;
        OP_ALUWR:  raw = (cur_flags & ~wmask) | (data & wmask);
        default:   raw = cur_flags;
      endcase
    end
  end

  psr_width_guard u_guard (
    .emu_in   (raw_emu),
    .flags_in (raw),
    .flags_out(nxt_flags)
  );
  assign nxt_emu = raw_emu;
endmodule

// File: rtl/psr_width_guard.sv
module psr_width_guard
  import psr_pkg::*;
(
  input  logic              emu_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out
);
  always_comb begin
    flags_out = flags_in;
    if (emu_in) begin
      flags_out[B_XW] = 1'b1;
      flags_out[B_MW] = 1'b1;
    end
  end
endmodule

// File: rtl/psr_edge_strobe.sv
module psr_edge_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_bit,
  input  logic nxt_bit,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= nxt_bit & ~cur_bit;
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [FLAG_W-1:0] cmd_data,
  input  logic [FLAG_W-1:0] cmd_mask,
  output logic [FLAG_W-1:0] flags,
  output logic              emu,
  output logic              acc_8bit,
  output logic              idx_8bit,
  output logic              idx_hi_clr
);
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              emu_q, emu_d;
  logic              take;

  assign cmd_ready = 1'b1;
  assign take      = cmd_valid & cmd_ready;

  psr_next_logic u_next (
    .take     (take),
    .op       (cmd_op),
    .data     (cmd_data),
    .wmask    (cmd_mask),
    .cur_flags(flags_q),
    .cur_emu  (emu_q),
    .nxt_flags(flags_d),
    .nxt_emu  (emu_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= RESET_FLAGS;
      emu_q   <= 1'b1;
    end else begin
      flags_q <= flags_d;
      emu_q   <= emu_d;
    end
  end

  psr_edge_strobe u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_bit(flags_q[B_XW]),
    .nxt_bit(flags_d[B_XW]),
    .pulse  (idx_hi_clr)
  );

  assign flags    = flags_q;
  assign emu      = emu_q;
  assign acc_8bit = flags_q[B_MW];
  assign idx_8bit = flags_q[B_XW];

  // R8
  emu_width_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu |-> (flags[B_XW] && flags[B_MW]));

  // R9
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_hi_clr |-> (idx_8bit && !$past(idx_8bit)));

  // R5
  swap_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SWAPCE) |=> (emu == $past(flags[B_CARRY]) && flags[B_CARRY] == $past(emu)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(flags) && $stable(emu)));

  // R3
  mask_clr_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MCLR && !emu) |=> ((flags & $past(cmd_data)) == '0));

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MSET) |=> ((flags & $past(cmd_data)) == $past(cmd_data)));
endmodule

// File: tb/sim_cpu_status_reg.sv
module sim_cpu_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [3:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic [7:0] cmd_mask = '0;
  logic [7:0] flags;
  logic       emu, acc_8bit, idx_8bit, idx_hi_clr;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_f;
  logic       m_e;
  logic       m_s;

  always #4 clk = ~clk;

  cpu_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .flags(flags), .emu(emu), .acc_8bit(acc_8bit), .idx_8bit(idx_8bit),
    .idx_hi_clr(idx_hi_clr)
  );

  function automatic logic [8:0] model_step(logic [7:0] f, logic e, logic v,
                                            logic [3:0] op, logic [7:0] d, logic [7:0] m);
    logic [7:0] n = f;
    logic       ne = e;
    if (v) begin
      if (op == 4'd1) n[0] = 1'b0;
      else if (op == 4'd2) n[3] = 1'b0;
      else if (op == 4'd3) n[2] = 1'b0;
      else if (op == 4'd4) n[6] = 1'b0;
      else if (op == 4'd5) n[0] = 1'b1;
      else if (op == 4'd6) n[3] = 1'b1;
      else if (op == 4'd7) n[2] = 1'b1;
      else if (op == 4'd8) n = f & ~d;
      else if (op == 4'd9) n = f | d;
      else if (op == 4'd10) begin n[0] = e; ne = f[0]; end
      else if (op == 4'd11) n = d;
      else if (op == 4'd12) n = (f & ~m) | (d & m);
    end
    if (ne) n = n | 8'h30;
    return {ne, n};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk({req, " flags"}, flags, m_f);
    chk({req, " emu"}, {7'd0, emu}, {7'd0, m_e});
    chk({req, " R9 strobe"}, {7'd0, idx_hi_clr}, {7'd0, m_s});
    chk({req, " R8 widths"}, {6'd0, acc_8bit, idx_8bit}, {6'd0, m_f[5], m_f[4]});
    chk({req, " R10 ready"}, {7'd0, cmd_ready}, 8'd1);
  endtask

  task automatic issue(string req, logic v, logic [3:0] op, logic [7:0] d, logic [7:0] m);
    logic [8:0] r;
    cmd_valid = v; cmd_op = op; cmd_data = d; cmd_mask = m;
    r = model_step(m_f, m_e, v, op, d, m);
    @(posedge clk);
    m_s = r[4] & ~m_f[4];
    m_f = r[7:0];
    m_e = r[8];
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_f = 8'h34; m_e = 1'b1; m_s = 1'b0;
    compare_all("R1 reset");
    issue("R3 R8 mask clear in emulation", 1'b1, 4'd8, 8'hFF, 8'h00);
    issue("R2 set carry", 1'b1, 4'd5, 8'h00, 8'h00);
    issue("R5 swap stays emulation", 1'b1, 4'd10, 8'h00, 8'h00);
    issue("R2 clear carry", 1'b1, 4'd1, 8'h00, 8'h00);
    issue("R5 swap into native", 1'b1, 4'd10, 8'h00, 8'h00);
    chk("R5 acc width after native entry", {7'd0, acc_8bit}, 8'd1);
    issue("R3 mask clear widths native", 1'b1, 4'd8, 8'h30, 8'h00);
    issue("R10 idle no valid", 1'b0, 4'd9, 8'hFF, 8'h00);
    issue("R10 reserved op 14", 1'b1, 4'd14, 8'hFF, 8'hFF);
    issue("R4 R9 mask set index width", 1'b1, 4'd9, 8'h10, 8'h00);
    issue("R9 strobe drops", 1'b0, 4'd0, 8'h00, 8'h00);
    issue("R6 pull", 1'b1, 4'd11, 8'hC3, 8'h00);
    issue("R7 alu write", 1'b1, 4'd12, 8'hA5, 8'h3C);
    issue("R11 set decimal", 1'b1, 4'd6, 8'h00, 8'h00);
    issue("R2 clear overflow", 1'b1, 4'd4, 8'h00, 8'h00);
    issue("R2 set irq", 1'b1, 4'd7, 8'h00, 8'h00);
    issue("R2 clear irq", 1'b1, 4'd3, 8'h00, 8'h00);
    issue("R2 clear decimal", 1'b1, 4'd2, 8'h00, 8'h00);
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      issue("R11 random", 1'($urandom_range(0, 3) != 0), op,
            8'($urandom), 8'($urandom));
    end
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_f = 8'h34; m_e = 1'b1; m_s = 1'b0;
    compare_all("R1 second reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule